// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address stream for a simple in-order pipeline whose branches carry one architectural delay slot. Each cycle it presents a fetch address with a valid flag. When the instruction at that address is a conditional branch, the pipeline raises a branch strobe in the same cycle. The strobe comes with the value of the branch's source register and a target address. The branch is taken when the register compares equal to zero. A parameter can flip the test to not-equal.

The sequencer never squashes the instruction that follows a branch. That word is always fetched next and runs as the delay slot. Only after it has issued does the address stream either jump to the latched target or carry on sequentially. A stall input freezes the address and any redirect that is still waiting. A branch strobe that lands on a delay-slot instruction is flagged as illegal and leaves the address stream alone.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While reset is asserted, the fetch address equals RESET_PC (default 0), the valid flag is 0 and the illegal flag is 0.
- R2: On an issuing cycle (valid high, stall low) with no redirect waiting, the next fetch address is the current one plus INSTR_BYTES (default 4), wrapping modulo 2^AW.
- R3: After an accepted branch issues, the next address is the branch address plus INSTR_BYTES (the delay slot), whether the branch is taken or not.
- R4: After the delay slot of a taken branch issues, the next address is the latched target with its low log2(INSTR_BYTES) bits forced to zero.
- R5: After the delay slot of a not-taken branch issues, the next address is the branch address plus twice INSTR_BYTES.
- R6: With BR_ON_NONZERO = 0, a branch is taken exactly when its source value is all zeros. With BR_ON_NONZERO = 1, it is taken exactly when the source value is nonzero.
- R7: While stall is high, the valid flag and the illegal flag are 0. The fetch address, the delay-slot state and any pending redirect hold unchanged. A branch strobe is ignored. The held redirect still takes effect once the stall clears.
- R8: A branch strobe on an issuing delay-slot instruction drives the illegal flag high in that cycle. It starts no new slot and no redirect, so the enclosing branch's sequencing alone decides the next address.
- R9: The valid flag rises one clock after reset is released, with the fetch address still at RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze fetch sequencing this cycle |
| br_valid_i | input | 1 | The instruction at the current fetch address is a resolved branch |
| br_src_i | input | DW | Source register value tested against zero |
| br_target_i | input | AW | Branch target byte address |
| fetch_pc_o | output | AW | Current fetch byte address |
| fetch_valid_o | output | 1 | Fetch address issues this cycle |
| br_illegal_o | output | 1 | Branch seen inside a delay slot this cycle |

## Verification
The bound checker checks these rules on every clock: the address step, the delay-slot step after any accepted branch, the jump to the latched target, the not-taken continuation, the taken decision against the zero test, the freeze under stall, and the clearing of the slot after an illegal branch. Some behaviour involves more than a one-cycle relation, and only the bench scenarios can show it. That covers whole taken and not-taken sequences, a redirect held across several stall cycles and applied later, an illegal branch whose own target must never appear, and the timing of the first valid fetch after reset. A long mixed phase of random stalls and branches is compared cycle by cycle against a behavioural model.

// File: rtl/dsf_pkg.sv
`timescale 1ns/1ps
package dsf_pkg;
   // Delay-slot tracking: no slot, slot with sequential follow-on, slot with redirect pending
   typedef enum logic [1:0] {
      SLOT_NONE  = 2'd0,
      SLOT_SEQ   = 2'd1,
      SLOT_REDIR = 2'd2
   } slot_state_e;
endpackage

// File: rtl/dsf_cond.sv
`timescale 1ns/1ps
module dsf_cond #(
   parameter int DW            = 32,
   parameter bit BR_ON_NONZERO = 1'b0
) (
   input  logic [DW-1:0] src_i,
   output logic          take_o
);
   logic is_zero;
   assign is_zero = (src_i == '0);

   generate
      if (BR_ON_NONZERO) begin : g_nez
         assign take_o = ~is_zero;
      end else begin : g_eqz
         assign take_o = is_zero;
      end
   endgenerate
endmodule

// File: rtl/dsf_slot_track.sv
`timescale 1ns/1ps
module dsf_slot_track
   import dsf_pkg::*;
#(
   parameter int AW          = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          br_go_i,
   input  logic          take_i,
   input  logic [AW-1:0] target_i,
   output logic          slot_o,
   output logic          pend_o,
   output logic [AW-1:0] tgt_o
);
   localparam logic [AW-1:0] LOW_BITS = AW'(INSTR_BYTES - 1);
   localparam logic [AW-1:0] KEEP     = ~LOW_BITS;

   slot_state_e   st_q;
   logic [AW-1:0] tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SLOT_NONE;
         tgt_q <= '0;
      end else if (adv_i) begin
         if (br_go_i) begin
            st_q <= take_i ? SLOT_REDIR : SLOT_SEQ;
         end else begin
            st_q <= SLOT_NONE;
         end
         if (br_go_i && take_i) begin
            tgt_q <= target_i & KEEP;
         end
      end
   end

   assign slot_o = (st_q != SLOT_NONE);
   assign pend_o = (st_q == SLOT_REDIR);
   assign tgt_o  = tgt_q;
endmodule

// File: rtl/dsf_pc_reg.sv
`timescale 1ns/1ps
module dsf_pc_reg #(
   parameter int          AW          = 32,
   parameter int          INSTR_BYTES = 4,
   parameter logic [31:0] RESET_PC    = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          redir_i,
   input  logic [AW-1:0] tgt_i,
   output logic [AW-1:0] pc_o
);
   localparam logic [AW-1:0] STEP  = AW'(INSTR_BYTES);
   localparam logic [AW-1:0] PC_RV = AW'(RESET_PC);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_d;

   always_comb begin
      pc_d = pc_q;
      if (adv_i) begin
         pc_d = redir_i ? tgt_i : (pc_q + STEP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= PC_RV;
      end else begin
         pc_q <= pc_d;
      end
   end

   assign pc_o = pc_q;
endmodule

// File: rtl/dslot_fetch_seq.sv
`timescale 1ns/1ps
module dslot_fetch_seq #(
   parameter int          AW            = 32,
   parameter int          DW            = 32,
   parameter int          INSTR_BYTES   = 4,
   parameter logic [31:0] RESET_PC      = 32'h0,
   parameter bit          BR_ON_NONZERO = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  logic          br_valid_i,
   input  logic [DW-1:0] br_src_i,
   input  logic [AW-1:0] br_target_i,
   output logic [AW-1:0] fetch_pc_o,
   output logic          fetch_valid_o,
   output logic          br_illegal_o
);
   localparam int ALIGN = $clog2(INSTR_BYTES);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("dslot_fetch_seq: AW must lie in 8..32");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dslot_fetch_seq: DW must be positive");
      end
      if (INSTR_BYTES < 1 || (1 << ALIGN) != INSTR_BYTES) begin : g_bad_step
         $error("dslot_fetch_seq: INSTR_BYTES must be a power of two");
      end
      if ((RESET_PC & (INSTR_BYTES - 1)) != 0) begin : g_bad_rpc
         $error("dslot_fetch_seq: RESET_PC must be instruction aligned");
      end
   endgenerate

   logic          valid_q;
   logic          issue;
   logic          br_seen;
   logic          br_go;
   logic          take_c;
   logic          slot_q;
   logic          pend_q;
   logic [AW-1:0] tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b1;
      end
   end

   assign issue   = valid_q & ~stall_i;
   assign br_seen = issue & br_valid_i;
   assign br_go   = br_seen & ~slot_q;

   dsf_cond #(
      .DW            (DW),
      .BR_ON_NONZERO (BR_ON_NONZERO)
   ) u_cond (
      .src_i  (br_src_i),
      .take_o (take_c)
   );

   dsf_slot_track #(
      .AW          (AW),
      .INSTR_BYTES (INSTR_BYTES)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (issue),
      .br_go_i  (br_go),
      .take_i   (take_c),
      .target_i (br_target_i),
      .slot_o   (slot_q),
      .pend_o   (pend_q),
      .tgt_o    (tgt_q)
   );

   dsf_pc_reg #(
      .AW          (AW),
      .INSTR_BYTES (INSTR_BYTES),
      .RESET_PC    (RESET_PC)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (issue),
      .redir_i (pend_q),
      .tgt_i   (tgt_q),
      .pc_o    (fetch_pc_o)
   );

   assign fetch_valid_o = issue;
   assign br_illegal_o  = br_seen & slot_q;
endmodule

// File: rtl/dsf_chk.sv
`timescale 1ns/1ps
module dsf_chk #(
   parameter int          AW            = 32,
   parameter int          DW            = 32,
   parameter int          INSTR_BYTES   = 4,
   parameter logic [31:0] RESET_PC      = 32'h0,
   parameter bit          BR_ON_NONZERO = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stall_i,
   input logic          br_valid_i,
   input logic [DW-1:0] br_src_i,
   input logic [AW-1:0] fetch_pc_o,
   input logic          fetch_valid_o,
   input logic          br_illegal_o,
   input logic          slot_q,
   input logic          pend_q,
   input logic [AW-1:0] tgt_q
);
   localparam logic [AW-1:0] STEP  = AW'(INSTR_BYTES);
   localparam logic [AW-1:0] PC_RV = AW'(RESET_PC);

   logic exp_take;
   assign exp_take = BR_ON_NONZERO ? (br_src_i != '0) : (br_src_i == '0);

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |-> (fetch_pc_o == PC_RV && !fetch_valid_o && !br_illegal_o));

   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && !pend_q) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP));

   a_r3_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && br_valid_i && !slot_q) |=> (slot_q && fetch_pc_o == $past(fetch_pc_o) + STEP));

   a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && pend_q) |=> (fetch_pc_o == $past(tgt_q) && !slot_q));

   a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && slot_q && !pend_q) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP && !slot_q));

   a_r6_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && br_valid_i && !slot_q) |=> (pend_q == $past(exp_take)));

   a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> ($stable(fetch_pc_o) && $stable(pend_q) && $stable(slot_q)));

   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> (!fetch_valid_o && !br_illegal_o));

   a_r8_no_nested_slot: assert property (@(posedge clk) disable iff (!rst_n)
      br_illegal_o |=> !slot_q);
endmodule

bind dslot_fetch_seq dsf_chk #(
   .AW            (AW),
   .DW            (DW),
   .INSTR_BYTES   (INSTR_BYTES),
   .RESET_PC      (RESET_PC),
   .BR_ON_NONZERO (BR_ON_NONZERO)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stall_i       (stall_i),
   .br_valid_i    (br_valid_i),
   .br_src_i      (br_src_i),
   .fetch_pc_o    (fetch_pc_o),
   .fetch_valid_o (fetch_valid_o),
   .br_illegal_o  (br_illegal_o),
   .slot_q        (slot_q),
   .pend_q        (pend_q),
   .tgt_q         (tgt_q)
);

// File: tb/dslot_fetch_seq_tb.sv
`timescale 1ns/1ps
module dslot_fetch_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 1'b0;
   logic        br_valid_i = 1'b0;
   logic [31:0] br_src_i = '0;
   logic [31:0] br_target_i = '0;
   logic [31:0] fetch_pc_o;
   logic        fetch_valid_o;
   logic        br_illegal_o;

   always #4 clk = ~clk;   // 125 MHz

   dslot_fetch_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .stall_i       (stall_i),
      .br_valid_i    (br_valid_i),
      .br_src_i      (br_src_i),
      .br_target_i   (br_target_i),
      .fetch_pc_o    (fetch_pc_o),
      .fetch_valid_o (fetch_valid_o),
      .br_illegal_o  (br_illegal_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // behavioural reference state
   logic [31:0] m_pc    = 32'h0;
   bit          m_valid = 1'b0;
   bit          m_slot  = 1'b0;
   bit          m_pend  = 1'b0;
   logic [31:0] m_tgt   = 32'h0;
   bit          last_ill;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // Drive inputs just after an edge, compare before the next, then advance the model.
   task automatic step(input bit st, input bit bv, input logic [31:0] src, input logic [31:0] tgt);
      bit go;
      bit tk;
      logic [31:0] npc;
      stall_i     = st;
      br_valid_i  = bv;
      br_src_i    = src;
      br_target_i = tgt;
      @(negedge clk);
      chk("R2 model fetch address", fetch_pc_o, m_pc);
      chk("R7 model valid", {31'b0, fetch_valid_o}, {31'b0, m_valid && !st});
      chk("R8 model illegal", {31'b0, br_illegal_o}, {31'b0, m_valid && !st && bv && m_slot});
      last_ill = br_illegal_o;
      @(posedge clk);
      if (!m_valid) begin
         m_valid = 1'b1;
      end else if (!st) begin
         go  = bv && !m_slot;
         tk  = go && (src == 32'h0);
         npc = m_pend ? m_tgt : m_pc + 32'd4;
         if (tk) m_tgt = tgt & ~32'd3;
         m_pend = tk;
         m_slot = go;
         m_pc   = npc;
      end
      #1;
   endtask

   initial begin
      #(8 * 50000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset address", fetch_pc_o, 32'h0);
      chk("R1 reset valid", {31'b0, fetch_valid_o}, 32'h0);
      chk("R1 reset illegal", {31'b0, br_illegal_o}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      m_valid = 1'b1;
      #1;
      chk("R9 first valid", {31'b0, fetch_valid_o}, 32'h1);
      chk("R9 first address", fetch_pc_o, 32'h0);

      step(0, 0, 32'h1, 32'h0);            // 0 -> 4
      step(0, 0, 32'h1, 32'h0);            // 4 -> 8
      chk("R2 sequential", fetch_pc_o, 32'h8);

      step(0, 1, 32'h0, 32'h103);          // taken branch at 8
      chk("R3 slot after taken", fetch_pc_o, 32'hC);
      step(0, 0, 32'h1, 32'h0);
      chk("R4 target aligned", fetch_pc_o, 32'h100);
      chk("R6 zero source taken", fetch_pc_o, 32'h100);
      step(0, 0, 32'h1, 32'h0);            // 100 -> 104

      step(0, 1, 32'h5, 32'h800);          // not taken at 104
      chk("R3 slot after not taken", fetch_pc_o, 32'h108);
      step(0, 0, 32'h1, 32'h0);
      chk("R5 fall through", fetch_pc_o, 32'h10C);
      chk("R6 nonzero source not taken", fetch_pc_o, 32'h10C);

      step(0, 1, 32'h0, 32'h200);          // taken at 10C
      for (int i = 0; i < 3; i++) step(1, 1, 32'h0, 32'h600);
      chk("R7 address held in stall", fetch_pc_o, 32'h110);
      step(0, 0, 32'h1, 32'h0);
      chk("R7 redirect kept over stall", fetch_pc_o, 32'h200);

      step(0, 1, 32'h0, 32'h300);          // taken at 200
      step(0, 1, 32'h0, 32'h400);          // branch inside slot at 204
      chk("R8 illegal flagged", {31'b0, last_ill}, 32'h1);
      chk("R8 outer redirect wins", fetch_pc_o, 32'h300);
      step(0, 0, 32'h1, 32'h0);
      chk("R8 no inner redirect", fetch_pc_o, 32'h304);

      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) == 0, ($urandom % 3) == 0,
              (($urandom % 2) == 0) ? 32'h0 : $urandom, $urandom);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule